// File: doc/BRIEF.md
# Clock Request Pin Reassignment Controller

This block decides which clock output pairs of a clock generator are running, and which of its dual-role pins behave as clock outputs and which as active-low clock request inputs. A small byte-addressed configuration store, written and read through a plain parallel port, holds a run enable for every output pair. It also holds role and routing bits for five dual-role pins. A pin moves into its request role only after the output that owns the pin has been switched off. While it is in that role, the synchronized level on the pin gates the run signal of a target pair. Some pins have a selectable target.

Two active-low stop inputs halt the CPU and PCI output groups, except for the outputs marked free-running. All pin and stop inputs go through a two-stage synchronizer. The run signals and pin direction controls are decoded combinationally from the stored configuration and the synchronized inputs. A configuration write therefore shows at the outputs in the cycle after the write edge.

Top module: `crq_ctrl`

## Requirements
- R1: After reset every direction bit `req_dir_in` is 0, meaning output role. The configuration bytes read 0x00, 0x07, 0x3F, 0xFF, 0x0F, 0x00, 0x00, 0x00 at addresses 0 to 7, so every output pair runs.
- R2: A write stores `wr_data` at `wr_addr` on the rising edge. From the next cycle, `rd_data` for that address returns the written byte exactly, including bits that have no function.
- R3: Request pin 0 takes its request role (direction bit 0 = 1) when byte 5 bit 7 is 1 and byte 2 bit 0 is 0. Byte 5 bit 6 selects its target: 0 = SRC0, 1 = SRC2.
- R4: Request pin 1 takes its request role when byte 5 bit 5 is 1 and byte 2 bit 1 is 0. Byte 5 bit 4 selects its target: 0 = SRC1, 1 = SRC4.
- R5: Request pins 2, 3 and 4 are enabled by byte 6 bits 7, 6 and 4, and their targets are SRC6, SRC8 and SRC10. Pins 2 and 3 are owned by byte 3 bit 3; pin 4 is owned by byte 3 bit 7.
- R6: While a pin's owning enable bit is 1, setting its role bit leaves the pin in output role. The level on that pin then has no effect on any run output.
- R7: The direction bit returns to 0 in the first cycle after the write that sets the owner enable again or clears the role bit.
- R8: A pin in request role at level 1 (deasserted) forces its target's run output to 0; at level 0 it does not. A pin change appears after the second rising edge, and not after the first.
- R9: Pair enables are bits 0-2 of byte 1 for CPU0-2, bits 0-5 of byte 2 for PCI0-5, bits 0-3 of byte 4 for SRC0-3 and bits 0-7 of byte 3 for SRC4-11. A pair whose bit is 0 does not run.
- R10: While `pci_stop_n` is 0 after synchronization, PCI0-4 stop and PCI5 (free-running) follows its enable only.
- R11: While `cpu_stop_n` is 0 after synchronization, CPU0 and CPU2 stop and CPU1 (free-running) follows its enable only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Write byte address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read byte address |
| rd_data | output | 8 | Read data for `rd_addr` |
| req_pin_n | input | 5 | Raw levels of the dual-role pins, active-low request |
| cpu_stop_n | input | 1 | Active-low stop for the CPU group |
| pci_stop_n | input | 1 | Active-low stop for the PCI group |
| req_dir_in | output | 5 | Per pin: 1 = request input role, 0 = clock output role |
| src_run | output | 12 | Run signals for SRC0-11 |
| pci_run | output | 6 | Run signals for PCI0-5 |
| cpu_run | output | 3 | Run signals for CPU0-2 |

## Verification
The assertions treat the synchronized request and stop levels as clean register outputs. They assume each configuration write targets an existing byte, which the 3-bit address always does. They also assume that any pin or stop change needs two edges to reach the gating logic. The stimulus changes pins and stop inputs only on falling edges. It then waits for two rising edges before comparing the outputs, and it issues one write at a time so that each decode can be checked in isolation. Every pin is swept through all combinations of owner enable, role bit, target select and pin level. The stop inputs are swept through all four combinations.

// File: rtl/crq_pkg.sv
package crq_pkg;
    localparam int REG_BYTES = 8;
    localparam int ADDR_W    = $clog2(REG_BYTES);
    localparam int CFG_W     = REG_BYTES * 8;
    localparam int NUM_REQ   = 5;
    localparam int NUM_SRC   = 12;
    localparam int NUM_PCI   = 6;
    localparam int NUM_CPU   = 3;

    localparam int BYTE_CPU_EN = 1;
    localparam int BYTE_PCI_EN = 2;
    localparam int BYTE_SRC_HI = 3;
    localparam int BYTE_SRC_LO = 4;
    localparam int BYTE_ROLE_A = 5;
    localparam int BYTE_ROLE_B = 6;

    localparam logic [CFG_W-1:0] CFG_RESET =
        {8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'h3F, 8'h07, 8'h00};

    function automatic int bpos(input int byte_i, input int bit_i);
        return byte_i * 8 + bit_i;
    endfunction

    // owning output enable of each dual-role pin
    function automatic int own_bit(input int pin);
        case (pin)
            0:       return bpos(BYTE_PCI_EN, 0);
            1:       return bpos(BYTE_PCI_EN, 1);
            2, 3:    return bpos(BYTE_SRC_HI, 3);
            default: return bpos(BYTE_SRC_HI, 7);
        endcase
    endfunction

    function automatic int role_bit(input int pin);
        case (pin)
            0:       return bpos(BYTE_ROLE_A, 7);
            1:       return bpos(BYTE_ROLE_A, 5);
            2:       return bpos(BYTE_ROLE_B, 7);
            3:       return bpos(BYTE_ROLE_B, 6);
            default: return bpos(BYTE_ROLE_B, 4);
        endcase
    endfunction

    function automatic bit has_sel(input int pin);
        return (pin == 0) || (pin == 1);
    endfunction

    function automatic int sel_bit(input int pin);
        case (pin)
            0:       return bpos(BYTE_ROLE_A, 6);
            1:       return bpos(BYTE_ROLE_A, 4);
            default: return 0;
        endcase
    endfunction

    function automatic int tgt_lo(input int pin);
        case (pin)
            0:       return 0;
            1:       return 1;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic int tgt_hi(input int pin);
        case (pin)
            0:       return 2;
            1:       return 4;
            default: return tgt_lo(pin);
        endcase
    endfunction

    function automatic int src_en_bit(input int pair);
        if (pair < 4) return bpos(BYTE_SRC_LO, pair);
        return bpos(BYTE_SRC_HI, pair - 4);
    endfunction
endpackage

// File: rtl/crq_regfile.sv
module crq_regfile
    import crq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [CFG_W-1:0]  cfg
);
    typedef struct packed {
        logic [CFG_W-1:0] bytes;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bytes[{wr_addr, 3'b000} +: 8] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bytes <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.bytes[{rd_addr, 3'b000} +: 8];
    assign cfg     = st_q.bytes;
endmodule

// File: rtl/crq_sync.sv
module crq_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.stg = {st_q.stg[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stg <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stg[STAGES-1];
endmodule

// File: rtl/crq_route.sv
module crq_route
    import crq_pkg::*;
#(
    parameter logic [NUM_PCI-1:0] PCI_FREE = 6'b100000,
    parameter logic [NUM_CPU-1:0] CPU_FREE = 3'b010
) (
    input  logic [CFG_W-1:0]   cfg,
    input  logic [NUM_REQ-1:0] req_lvl,
    input  logic               cpu_go,
    input  logic               pci_go,
    output logic [NUM_REQ-1:0] role_in,
    output logic [NUM_SRC-1:0] src_run,
    output logic [NUM_PCI-1:0] pci_run,
    output logic [NUM_CPU-1:0] cpu_run
);
    logic [NUM_SRC-1:0] hold;

    // role decode and request routing
    always_comb begin
        int tgt;
        hold    = '0;
        role_in = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            role_in[i] = cfg[role_bit(i)] & ~cfg[own_bit(i)];
            tgt = (has_sel(i) && cfg[sel_bit(i)]) ? tgt_hi(i) : tgt_lo(i);
            if (role_in[i] && req_lvl[i]) begin
                hold[tgt] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_SRC; p++) begin
            src_run[p] = cfg[src_en_bit(p)] & ~hold[p];
        end
        for (int k = 0; k < NUM_PCI; k++) begin
            pci_run[k] = cfg[bpos(BYTE_PCI_EN, k)] & (pci_go | PCI_FREE[k]);
        end
        for (int k = 0; k < NUM_CPU; k++) begin
            cpu_run[k] = cfg[bpos(BYTE_CPU_EN, k)] & (cpu_go | CPU_FREE[k]);
        end
    end
endmodule

// File: rtl/crq_ctrl.sv
module crq_ctrl
    import crq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_PCI-1:0] PCI_FREE = 6'b100000,
    parameter logic [NUM_CPU-1:0] CPU_FREE = 3'b010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [7:0]         rd_data,
    input  logic [NUM_REQ-1:0] req_pin_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    output logic [NUM_REQ-1:0] req_dir_in,
    output logic [NUM_SRC-1:0] src_run,
    output logic [NUM_PCI-1:0] pci_run,
    output logic [NUM_CPU-1:0] cpu_run
);
    localparam int SYNC_W = NUM_REQ + 2;

    logic [CFG_W-1:0]   cfg_w;
    logic [SYNC_W-1:0]  sync_w;
    logic [NUM_REQ-1:0] req_s;
    logic               cpu_go_s;
    logic               pci_go_s;

    crq_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg_w)
    );

    crq_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cpu_stop_n, pci_stop_n, req_pin_n}),
        .dout  (sync_w)
    );

    assign req_s    = sync_w[NUM_REQ-1:0];
    assign pci_go_s = sync_w[NUM_REQ];
    assign cpu_go_s = sync_w[NUM_REQ+1];

    crq_route #(
        .PCI_FREE (PCI_FREE),
        .CPU_FREE (CPU_FREE)
    ) u_route (
        .cfg     (cfg_w),
        .req_lvl (req_s),
        .cpu_go  (cpu_go_s),
        .pci_go  (pci_go_s),
        .role_in (req_dir_in),
        .src_run (src_run),
        .pci_run (pci_run),
        .cpu_run (cpu_run)
    );
endmodule

// File: rtl/crq_ctrl_chk.sv
module crq_ctrl_chk
    import crq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [7:0]         wr_data,
    input logic [CFG_W-1:0]   cfg,
    input logic [NUM_REQ-1:0] req_s,
    input logic               cpu_go,
    input logic               pci_go,
    input logic [NUM_REQ-1:0] req_dir_in,
    input logic [NUM_SRC-1:0] src_run,
    input logic [NUM_PCI-1:0] pci_run,
    input logic [NUM_CPU-1:0] cpu_run
);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg[{$past(wr_addr), 3'b000} +: 8] == $past(wr_data));

    a_r3_owner_off_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_dir_in[0] |-> !pci_run[0]);

    a_r5_owner_off_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_dir_in[2] || req_dir_in[3] || req_dir_in[4]) |-> !(cfg[27] && cfg[31] && req_dir_in[4]));

    a_r6_role_held_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[47] && cfg[16]) |-> !req_dir_in[0]);

    a_r7_prompt_return: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg[16]) |-> !req_dir_in[0]);

    a_r8_request_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (req_dir_in[0] && !cfg[46] && req_s[0]) |-> !src_run[0]);

    a_r9_disabled_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[8] |-> !cpu_run[0]);

    a_r10_pci_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_go |-> (pci_run[4:0] == 5'b0 && pci_run[5] == cfg[21]));

    a_r11_cpu_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_go |-> (!cpu_run[0] && !cpu_run[2] && cpu_run[1] == cfg[9]));
endmodule

bind crq_ctrl crq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cfg        (cfg_w),
    .req_s      (req_s),
    .cpu_go     (cpu_go_s),
    .pci_go     (pci_go_s),
    .req_dir_in (req_dir_in),
    .src_run    (src_run),
    .pci_run    (pci_run),
    .cpu_run    (cpu_run)
);

// File: tb/crq_ctrl_bench.sv
module crq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [4:0]  req_pin_n = '0;
    logic        cpu_stop_n = 1'b1;
    logic        pci_stop_n = 1'b1;
    logic [4:0]  req_dir_in;
    logic [11:0] src_run;
    logic [5:0]  pci_run;
    logic [2:0]  cpu_run;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] m [8];
    logic [7:0] rst_vals [8];

    always #10 clk = ~clk;

    crq_ctrl u_crq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_pin_n(req_pin_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .req_dir_in(req_dir_in), .src_run(src_run), .pci_run(pci_run),
        .cpu_run(cpu_run)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m[a] = d;
    endtask

    task automatic set_bit(input int a, input int b, input logic v);
        logic [7:0] t;
        t = m[a];
        t[b] = v;
        wr(a, t);
    endtask

    task automatic drive_pins(input logic [4:0] lv, input logic cs, input logic ps);
        @(negedge clk);
        req_pin_n = lv; cpu_stop_n = cs; pci_stop_n = ps;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        logic [4:0]  d;
        logic [11:0] s;
        logic [5:0]  p;
        logic [2:0]  c;
        d[0] = m[5][7] & ~m[2][0];
        d[1] = m[5][5] & ~m[2][1];
        d[2] = m[6][7] & ~m[3][3];
        d[3] = m[6][6] & ~m[3][3];
        d[4] = m[6][4] & ~m[3][7];
        for (int i = 0; i < 12; i++) s[i] = (i < 4) ? m[4][i] : m[3][i-4];
        if (d[0] && req_pin_n[0]) s[m[5][6] ? 2 : 0] = 1'b0;
        if (d[1] && req_pin_n[1]) s[m[5][4] ? 4 : 1] = 1'b0;
        if (d[2] && req_pin_n[2]) s[6]  = 1'b0;
        if (d[3] && req_pin_n[3]) s[8]  = 1'b0;
        if (d[4] && req_pin_n[4]) s[10] = 1'b0;
        for (int i = 0; i < 6; i++) p[i] = m[2][i] & (pci_stop_n | (i == 5));
        for (int i = 0; i < 3; i++) c[i] = m[1][i] & (cpu_stop_n | (i == 1));
        check({tag, " dir"}, 32'(req_dir_in), 32'(d));
        check({tag, " src"}, 32'(src_run), 32'(s));
        check({tag, " pci"}, 32'(pci_run), 32'(p));
        check({tag, " cpu"}, 32'(cpu_run), 32'(c));
    endtask

    task automatic restore_defaults();
        for (int a = 0; a < 8; a++) wr(a, rst_vals[a]);
    endtask

    initial begin
        rst_vals = '{8'h00, 8'h07, 8'h3F, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00};
        m = rst_vals;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset contents and outputs
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); rd_addr = 3'(a); #1;
            check($sformatf("R1 reset byte %0d", a), 32'(rd_data), 32'(rst_vals[a]));
        end
        check_outputs("R1 reset");

        // R2: readback of arbitrary patterns on every byte
        for (int a = 0; a < 8; a++) wr(a, 8'(8'hA5 ^ (a * 37)));
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); rd_addr = 3'(a); #1;
            check($sformatf("R2 readback byte %0d", a), 32'(rd_data), 32'(8'(8'hA5 ^ (a * 37))));
        end
        check_outputs("R2 pattern decode");
        restore_defaults();

        // R3/R4/R5/R6: sweep owner, role, select and level for every pin
        for (int pin = 0; pin < 5; pin++) begin
            int ob, obit, rb, rbit, sb;
            case (pin)
                0: begin ob = 2; obit = 0; rb = 7; rbit = 5; sb = 6; end
                1: begin ob = 2; obit = 1; rb = 5; rbit = 5; sb = 4; end
                2: begin ob = 3; obit = 3; rb = 7; rbit = 6; sb = -1; end
                3: begin ob = 3; obit = 3; rb = 6; rbit = 6; sb = -1; end
                default: begin ob = 3; obit = 7; rb = 4; rbit = 6; sb = -1; end
            endcase
            for (int k = 0; k < 16; k++) begin
                string tg;
                logic [4:0] lv;
                tg = (pin == 0) ? "R3" : (pin == 1) ? "R4" : "R5";
                if (k[1] && !k[0]) tg = {tg, "/R6"};
                set_bit(ob, obit, ~k[0]);
                set_bit(rbit, rb, k[1]);
                if (sb >= 0) set_bit(5, sb, k[2]);
                lv = '0;
                lv[pin] = k[3];
                drive_pins(lv, 1'b1, 1'b1);
                check_outputs($sformatf("%s pin%0d k%0d", tg, pin, k));
            end
            restore_defaults();
            drive_pins(5'b0, 1'b1, 1'b1);
        end

        // R7: owner re-enabled, direction back at once
        set_bit(2, 0, 1'b0);
        set_bit(5, 7, 1'b1);
        check_outputs("R7 role on");
        set_bit(2, 0, 1'b1);
        check("R7 dir after owner on", 32'(req_dir_in[0]), 32'(0));
        set_bit(2, 0, 1'b0);
        set_bit(5, 7, 1'b0);
        check("R7 dir after role off", 32'(req_dir_in[0]), 32'(0));
        set_bit(5, 7, 1'b1);

        // R8: two-edge latency on a request change to SRC0
        drive_pins(5'b0, 1'b1, 1'b1);
        check("R8 request asserted runs", 32'(src_run[0]), 32'(1));
        @(negedge clk); req_pin_n = 5'b00001;
        @(posedge clk); @(negedge clk);
        check("R8 one edge no change", 32'(src_run[0]), 32'(1));
        @(posedge clk); @(negedge clk);
        check("R8 two edges stopped", 32'(src_run[0]), 32'(0));
        restore_defaults();
        drive_pins(5'b0, 1'b1, 1'b1);

        // R9: clear each enable byte in turn
        for (int a = 1; a < 5; a++) begin
            wr(a, 8'h00);
            check_outputs($sformatf("R9 byte %0d cleared", a));
            wr(a, rst_vals[a]);
        end

        // R10/R11: stop input combinations
        for (int k = 0; k < 4; k++) begin
            drive_pins(5'b0, k[0], k[1]);
            check_outputs($sformatf("R10/R11 stops cs=%0d ps=%0d", k[0], k[1]));
        end
        wr(2, 8'h1F);
        drive_pins(5'b0, 1'b1, 1'b0);
        check("R10 free PCI5 disabled", 32'(pci_run[5]), 32'(0));
        wr(1, 8'h05);
        drive_pins(5'b0, 1'b0, 1'b1);
        check("R11 free CPU1 disabled", 32'(cpu_run[1]), 32'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule